// File: doc/BRIEF.md
# Priority-Weighted Two-Thread Decode Slot Arbiter

This block decides, on every cycle, which of two hardware threads may use the decode stage. Each thread holds a 3-bit priority from 0 to 7. Software changes a priority with a priority-set request. The request carries a target thread, a 5-bit register-number code and the requester's privilege level. The arbiter maps the code to a priority and checks it against the privilege level. An accepted request updates the thread's priority register. A request that is not accepted leaves the register as it was.

The arbiter works in rounds. With priorities that differ by `d`, a round lasts `2^(d+1)` cycles. The thread with the higher priority decodes in every slot of the round except the last one, which goes to the other thread. Some settings switch the arbiter into special modes:

- Priority 0 switches a thread off.
- Priority 7 gives one thread every slot.
- When both threads hold priority 1, the arbiter enters a low-power mode with a single decode slot every 32 cycles.

A new priority is latched only at a round boundary, so a round that has started always runs to its end.

Top module: `prio_slot_arbiter`

## Requirements
- R1: After reset both priorities read 4. The first cycle after reset grants thread A, and the next cycle grants thread B.
- R2: Codes map to priorities as follows: code 0 gives 0, 31 gives 1, 1 gives 2, 6 gives 3, 2 gives 4, 5 gives 5, 3 gives 6, and 7 gives 7. Every other code is unrecognised.
- R3: The privilege encoding is 0 for user, 1 for supervisor, 2 for hypervisor and 3 for reserved. User may set priorities 2 to 4. Supervisor may set 1 to 6. Hypervisor may set 0 to 7. Reserved may set nothing.
- R4: A rejected request leaves both priority registers unchanged. An accepted request changes only the target thread's register, and the new value is visible on the cycle after the request.
- R5: `grant_o` is one-hot or zero. Bit 0 grants thread A and bit 1 grants thread B.
- R6: When neither priority is 0 or 7 and the two are not both 1, each round lasts `L = 2^(|Pa-Pb|+1)` cycles. The higher-priority thread is granted in L-1 slots. The other thread is granted only in the last slot of the round.
- R7: At equal priority the round is 2 cycles long: thread A is granted first, then thread B.
- R8: A thread at priority 0 is never granted, and the other thread is granted every cycle. If both threads are at 0, no thread is granted.
- R9: A thread at priority 7 is granted every cycle and the other thread is never granted. If both threads are at 7, they alternate as in R7.
- R10: When both priorities are 1, exactly one grant is issued per 32 cycles, and successive grants alternate between the threads.
- R11: A priority change takes effect at the next round boundary. The slots left in the current round follow the priorities that were latched when the round began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_valid_i | input | 1 | Priority-set request strobe |
| set_thread_i | input | 1 | Target thread of the request (0 = A, 1 = B) |
| set_code_i | input | 5 | Register-number code of the request |
| set_priv_i | input | 2 | Privilege level of the request |
| grant_o | output | 2 | Per-cycle decode grant, one-hot or zero |
| prio_a_o | output | 3 | Current priority register of thread A |
| prio_b_o | output | 3 | Current priority register of thread B |

## Verification
The bench tries all 64 priority pairs. For each pair it counts the grants to each thread over a 128-cycle window. Because 128 is a whole number of rounds for every round length and for the alternating low-power period, the counts do not depend on where the window starts. The counts separate the ratio formula, the equal-priority case, the off and single-thread modes, their order of precedence, and the low-power mode.

It also applies every code at every privilege level to both threads, each time from two different starting priorities, so that an accepted request can be told apart from a rejected one. A final test changes a priority in the middle of a 32-cycle round. It then checks that the rest of the round keeps the old split before the new alternation begins.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int PRIO_W   = 3;
  localparam int CODE_W   = 5;
  localparam int NUM_THR  = 2;
  localparam int PRIO_MAX = (1 << PRIO_W) - 1;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_HYPER = 2'd2,
    PRIV_RSVD  = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_ONLY_A,
    MODE_ONLY_B,
    MODE_RATIO,
    MODE_LOWPWR
  } mode_e;

  // 7 wins over 0; both-0 idles; both-1 sleeps
  function automatic mode_e pick_mode(prio_t a, prio_t b);
    mode_e m;
    if (a == prio_t'(PRIO_MAX) && b != prio_t'(PRIO_MAX))      m = MODE_ONLY_A;
    else if (b == prio_t'(PRIO_MAX) && a != prio_t'(PRIO_MAX)) m = MODE_ONLY_B;
    else if (a == '0 && b == '0)                               m = MODE_IDLE;
    else if (a == '0)                                          m = MODE_ONLY_B;
    else if (b == '0)                                          m = MODE_ONLY_A;
    else if (a == prio_t'(1) && b == prio_t'(1))               m = MODE_LOWPWR;
    else                                                       m = MODE_RATIO;
    return m;
  endfunction
endpackage

// File: rtl/prio_code_decode.sv
module prio_code_decode
  import prio_arb_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        priv_i,
  output logic              ok_o,
  output prio_t             prio_o
);
  logic known;
  logic allowed;

  always_comb begin
    known  = 1'b1;
    prio_o = '0;
    unique case (code_i)
      5'd0:    prio_o = prio_t'(0);
      5'd31:   prio_o = prio_t'(1);
      5'd1:    prio_o = prio_t'(2);
      5'd6:    prio_o = prio_t'(3);
      5'd2:    prio_o = prio_t'(4);
      5'd5:    prio_o = prio_t'(5);
      5'd3:    prio_o = prio_t'(6);
      5'd7:    prio_o = prio_t'(7);
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    unique case (priv_e'(priv_i))
      PRIV_USER:  allowed = (prio_o >= prio_t'(2)) && (prio_o <= prio_t'(4));
      PRIV_SUPER: allowed = (prio_o >= prio_t'(1)) && (prio_o <= prio_t'(6));
      PRIV_HYPER: allowed = 1'b1;
      default:    allowed = 1'b0;
    endcase
  end

  assign ok_o = known && allowed;
endmodule

// File: rtl/prio_regs.sv
module prio_regs
  import prio_arb_pkg::*;
#(
  parameter prio_t RESET_PRIO = prio_t'(4)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic                            wr_thread_i,
  input  prio_t                           wr_prio_i,
  output logic [NUM_THR-1:0][PRIO_W-1:0]  prio_o
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   prio_o[t] <= RESET_PRIO;
      else if (wr_en_i && (wr_thread_i == 1'(t)))    prio_o[t] <= wr_prio_i;
    end
  end
endmodule

// File: rtl/prio_slot_seq.sv
module prio_slot_seq
  import prio_arb_pkg::*;
#(
  parameter int    LP_PERIOD  = 32,
  parameter prio_t RESET_PRIO = prio_t'(4)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  prio_t              prio_a_i,
  input  prio_t              prio_b_i,
  output logic [NUM_THR-1:0] grant_o
);
  localparam int MAX_DIFF  = PRIO_MAX - 2;
  localparam int MAX_ROUND = 1 << (MAX_DIFF + 1);
  localparam int SPAN      = (MAX_ROUND > LP_PERIOD) ? MAX_ROUND : LP_PERIOD;
  localparam int CNT_W     = $clog2(SPAN);

  prio_t             cur_a_q, cur_b_q;
  logic [CNT_W-1:0]  cnt_q, last;
  logic              lp_turn_q;
  logic              hi_b, round_end;
  prio_t             diff;
  mode_e             mode;

  always_comb begin
    mode = pick_mode(cur_a_q, cur_b_q);
    hi_b = cur_b_q > cur_a_q;
    diff = hi_b ? (cur_b_q - cur_a_q) : (cur_a_q - cur_b_q);
    unique case (mode)
      MODE_RATIO:  last = CNT_W'((32'd2 << diff) - 32'd1);
      MODE_LOWPWR: last = CNT_W'(LP_PERIOD - 1);
      default:     last = '0;
    endcase
  end

  assign round_end = (cnt_q == last);

  // priorities are only sampled at a round boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_a_q   <= RESET_PRIO;
      cur_b_q   <= RESET_PRIO;
      cnt_q     <= '0;
      lp_turn_q <= 1'b0;
    end else if (round_end) begin
      cur_a_q <= prio_a_i;
      cur_b_q <= prio_b_i;
      cnt_q   <= '0;
      if (mode == MODE_LOWPWR) lp_turn_q <= ~lp_turn_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_ONLY_A: grant_o = 2'b01;
      MODE_ONLY_B: grant_o = 2'b10;
      MODE_LOWPWR: grant_o = (cnt_q == '0) ? (lp_turn_q ? 2'b10 : 2'b01) : 2'b00;
      MODE_RATIO:  grant_o = (round_end ^ hi_b) ? 2'b10 : 2'b01;
      default:     grant_o = 2'b00;
    endcase
  end
endmodule

// File: rtl/prio_slot_arbiter.sv
module prio_slot_arbiter
  import prio_arb_pkg::*;
#(
  parameter int    LP_PERIOD  = 32,
  parameter prio_t RESET_PRIO = prio_t'(4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_valid_i,
  input  logic              set_thread_i,
  input  logic [CODE_W-1:0] set_code_i,
  input  logic [1:0]        set_priv_i,
  output logic [1:0]        grant_o,
  output logic [PRIO_W-1:0] prio_a_o,
  output logic [PRIO_W-1:0] prio_b_o
);
  logic                           dec_ok;
  prio_t                          dec_prio;
  logic [NUM_THR-1:0][PRIO_W-1:0] prio_q;

  prio_code_decode u_dec (
    .code_i (set_code_i),
    .priv_i (set_priv_i),
    .ok_o   (dec_ok),
    .prio_o (dec_prio)
  );

  prio_regs #(.RESET_PRIO(RESET_PRIO)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (set_valid_i && dec_ok),
    .wr_thread_i (set_thread_i),
    .wr_prio_i   (dec_prio),
    .prio_o      (prio_q)
  );

  prio_slot_seq #(.LP_PERIOD(LP_PERIOD), .RESET_PRIO(RESET_PRIO)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prio_a_i (prio_q[0]),
    .prio_b_i (prio_q[1]),
    .grant_o  (grant_o)
  );

  assign prio_a_o = prio_q[0];
  assign prio_b_o = prio_q[1];
endmodule

// File: rtl/prio_slot_arbiter_chk.sv
module prio_slot_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       set_valid_i,
  input logic       set_thread_i,
  input logic [1:0] set_priv_i,
  input logic [1:0] grant_o,
  input logic [2:0] prio_a_o,
  input logic [2:0] prio_b_o
);
  assert_grant_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_valid_i |=> ($stable(prio_a_o) && $stable(prio_b_o)));

  assert_other_thread_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_valid_i && !set_thread_i) |=> $stable(prio_b_o));

  assert_user_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_valid_i && set_priv_i == 2'd0 && !set_thread_i)
      |=> (prio_a_o == $past(prio_a_o) || (prio_a_o >= 3'd2 && prio_a_o <= 3'd4)));

  assert_super_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_valid_i && set_priv_i == 2'd1 && set_thread_i)
      |=> (prio_b_o == $past(prio_b_o) || (prio_b_o != 3'd0 && prio_b_o != 3'd7)));

  assert_rsvd_noop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_valid_i && set_priv_i == 2'd3) |=> ($stable(prio_a_o) && $stable(prio_b_o)));
endmodule

bind prio_slot_arbiter prio_slot_arbiter_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .set_valid_i  (set_valid_i),
  .set_thread_i (set_thread_i),
  .set_priv_i   (set_priv_i),
  .grant_o      (grant_o),
  .prio_a_o     (prio_a_o),
  .prio_b_o     (prio_b_o)
);

// File: tb/prio_slot_arbiter_bench.sv
`timescale 1ns/1ps
module prio_slot_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       set_valid = 1'b0;
  logic       set_thread = 1'b0;
  logic [4:0] set_code = '0;
  logic [1:0] set_priv = '0;
  logic [1:0] grant;
  logic [2:0] prio_a, prio_b;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  prio_slot_arbiter u_prio_slot_arbiter (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .set_valid_i  (set_valid),
    .set_thread_i (set_thread),
    .set_code_i   (set_code),
    .set_priv_i   (set_priv),
    .grant_o      (grant),
    .prio_a_o     (prio_a),
    .prio_b_o     (prio_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2 map, -1 = unrecognised
  function automatic int code_prio(input int c);
    case (c)
      0: return 0;  31: return 1; 1: return 2; 6: return 3;
      2: return 4;  5: return 5;  3: return 6; 7: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic int prio_code(input int p);
    for (int c = 0; c < 32; c++) if (code_prio(c) == p) return c;
    return 8;
  endfunction

  // R3 privilege ranges
  function automatic bit priv_allows(input int priv, input int p);
    case (priv)
      0: return p >= 2 && p <= 4;
      1: return p >= 1 && p <= 6;
      2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic request(input bit thr, input int code, input int priv);
    @(negedge clk);
    set_valid  = 1'b1;
    set_thread = thr;
    set_code   = 5'(code);
    set_priv   = 2'(priv);
    @(negedge clk);
    set_valid  = 1'b0;
  endtask

  // grants per 128-cycle window, from R6..R10
  task automatic expect_counts(input int a, input int b, output int ea, output int eb);
    int l;
    if (a == 7 && b != 7)      begin ea = 128; eb = 0;   end
    else if (b == 7 && a != 7) begin ea = 0;   eb = 128; end
    else if (a == 0 && b == 0) begin ea = 0;   eb = 0;   end
    else if (a == 0)           begin ea = 0;   eb = 128; end
    else if (b == 0)           begin ea = 128; eb = 0;   end
    else if (a == 1 && b == 1) begin ea = 2;   eb = 2;   end
    else begin
      l = 2 << ((a > b) ? a - b : b - a);
      if (a >= b) begin ea = 128 - 128 / l; eb = 128 / l; end
      else        begin eb = 128 - 128 / l; ea = 128 / l; end
    end
  endtask

  initial begin
    int ca, cb, ea, eb, both, g, exp_p, before_o, guard;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(prio_a == 3'd4, "R1 prio_a", prio_a, 4);
    check(prio_b == 3'd4, "R1 prio_b", prio_b, 4);
    check(grant == 2'b01, "R1 first grant", grant, 1);
    @(negedge clk);
    check(grant == 2'b10, "R1 second grant", grant, 2);

    // R2 R3 R4: every code x privilege x thread, two baselines
    for (int base = 0; base < 2; base++) begin
      for (int thr = 0; thr < 2; thr++) begin
        for (int code = 0; code < 32; code++) begin
          for (int priv = 0; priv < 4; priv++) begin
            request(thr[0], base ? 7 : 0, 2);
            before_o = thr ? prio_a : prio_b;
            request(thr[0], code, priv);
            if (code_prio(code) >= 0 && priv_allows(priv, code_prio(code)))
              exp_p = code_prio(code);
            else
              exp_p = base ? 7 : 0;
            g = thr ? prio_b : prio_a;
            check(g == exp_p, "R2/R3 decode and privilege", g, exp_p);
            g = thr ? prio_a : prio_b;
            check(g == before_o, "R4 other thread untouched", g, before_o);
          end
        end
      end
    end

    // R5..R10: all priority pairs, 128-cycle windows
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        request(1'b0, prio_code(a), 2);
        request(1'b1, prio_code(b), 2);
        repeat (140) @(negedge clk);
        ca = 0; cb = 0; both = 0;
        for (int k = 0; k < 128; k++) begin
          @(negedge clk);
          if (grant[0]) ca++;
          if (grant[1]) cb++;
          if (grant == 2'b11) both++;
        end
        expect_counts(a, b, ea, eb);
        check(both == 0, "R5 onehot grant", both, 0);
        check(ca == ea, "R6-R10 grants to A (R6 R7 R8 R9 R10)", ca, ea);
        check(cb == eb, "R6-R10 grants to B (R6 R7 R8 R9 R10)", cb, eb);
      end
    end

    // R11: change mid-round of a 31:1 split
    request(1'b0, prio_code(6), 2);
    request(1'b1, prio_code(2), 2);
    repeat (140) @(negedge clk);
    guard = 0;
    while (grant != 2'b10 && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(grant == 2'b01, "R11 round start", grant, 1);
    set_valid = 1'b1; set_thread = 1'b0; set_code = 5'd1; set_priv = 2'd2;
    @(negedge clk);
    set_valid = 1'b0;
    check(prio_a == 3'd2, "R11 register updated", prio_a, 2);
    ca = 0;
    for (int k = 0; k < 30; k++) begin
      if (grant == 2'b01) ca++;
      @(negedge clk);
    end
    check(ca == 30, "R11 old split kept", ca, 30);
    check(grant == 2'b10, "R11 lower slot at round end", grant, 2);
    @(negedge clk);
    check(grant == 2'b01, "R11 new round A", grant, 1);
    @(negedge clk);
    check(grant == 2'b10, "R11 new round B", grant, 2);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(2_000_000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule